// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This peripheral guards a system against runaway software. An 8-bit up-counter advances on ticks from a power-of-two prescaler. In watchdog mode, a wrap of the counter from 255 to 0 latches an overflow flag. If reset generation is armed, the same wrap also drives a fixed-length system reset pulse.

Software reaches the block through three 16-bit word registers: control at offset 0, count at offset 2 and reset control at offset 4. The upper byte of every write must hold a key chosen by the target register. A store with the wrong key changes nothing, so a stray store cannot disarm the timer.

The overflow flag outlives the reset pulse. Only power-on reset or a keyed clear removes it, and the clear works only after software has read the flag.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset every register reads 0x0000 and `reset_o` is low.
- R2: A write to offset 0 takes effect only with upper byte 0xA5, and writes to offsets 2 and 4 only with upper byte 0x5A. Any other write changes nothing.
- R3: Offset 0 reads back as {8'h00, 1'b0, watchdog mode (bit 6), timer enable (bit 5), select field in the low SEL_W bits}.
- R4: The prescaler divides the input clock by 2^(2·s) when SEL_W is 3, and by 1 for s=0 or 2^(s+7) otherwise when SEL_W is 4. So s=7 gives 16384 and s=15 gives 4194304.
- R5: The counter counts up and wraps after 255, so a load value N reaches overflow after 256−N ticks. The first tick lands one divisor period of clock edges after the enabling write.
- R6: A wrap in watchdog mode sets the overflow flag, read at bit 7 of offset 4. A wrap with watchdog mode off sets no flag.
- R7: A watchdog-mode wrap with reset enable (bit 6 of offset 4) set drives `reset_o` high for 16 clock cycles. The flag stays set through the pulse.
- R8: Writing exactly 0xA500 to offset 4 clears the flag, but only if offset 4 has been read while the flag was set. Without that read the write is ignored.
- R9: Clearing the timer-enable bit halts the counter at its value and resets the prescaler. A stopped counter still accepts a keyed load at offset 2.
- R10: Offset 4 reads back as {8'h00, flag, reset enable, 6'b0}, and offset 2 as {8'h00, count}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock feeding the prescaler |
| rst_ni | input | 1 | Active-low power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (needed to arm the flag clear) |
| addr_i | input | 3 | Byte offset: 0, 2 or 4 |
| wdata_i | input | 16 | Write word: key in the upper byte, data in the lower byte |
| rdata_o | output | 16 | Read word for the addressed register |
| reset_o | output | 1 | System reset pulse |

## Verification
The counter is run with prescaler selects 0, 1, 3 and 7, each stopped after a known number of edges. The count that remains shows whether the divisor is right and whether the first tick lands on the correct edge. The count to 16383 and then 16384 edges at the largest select separates an exact divisor from one that is off by one.

Wraps are driven both with watchdog mode off and with it on. Reset enable is set for the mode-on wrap, which tells flag setting apart from plain wrapping and gives a pulse to measure.

Clear attempts are made both before and after a flag read, which exposes a missing read guard. Writes with the wrong key go to each offset, and a load value of 0xFC is stopped one tick short of overflow and then run past it.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        reset_o
);

  localparam int PRE_W   = (SEL_W == 4) ? 22 : 14;
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [7:0] KEY_CTL = 8'hA5;
  localparam logic [7:0] KEY_DAT = 8'h5A;
  localparam logic [15:0] CLR_WORD = 16'hA500;

  logic             wt_q, tme_q, rste_q, ovf_q, seen_q;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       cnt_q;
  logic [PRE_W-1:0] pre_q, lim;
  logic [4:0]       shift;
  logic [PULSE_W-1:0] pls_q;

  wire wr_ctl = wr_en_i && addr_i == 3'd0 && wdata_i[15:8] == KEY_CTL;
  wire wr_cnt = wr_en_i && addr_i == 3'd2 && wdata_i[15:8] == KEY_DAT;
  wire wr_rcr = wr_en_i && addr_i == 3'd4 && wdata_i[15:8] == KEY_DAT;
  wire clr_rq = wr_en_i && addr_i == 3'd4 && wdata_i == CLR_WORD;
  wire rd_rcr = rd_en_i && addr_i == 3'd4;

  generate
    if (SEL_W == 4) begin : g_sel4
      assign shift = (sel_q == '0) ? 5'd0 : 5'(sel_q) + 5'd7;
    end else begin : g_sel3
      assign shift = 5'({sel_q, 1'b0});
    end
  endgenerate

  assign lim = (PRE_W'(1) << shift) - PRE_W'(1);

  wire tick     = tme_q && pre_q == lim;
  wire wrap     = tick && cnt_q == 8'hFF;
  wire set_flag = wrap && wt_q;
  wire fire     = set_flag && rste_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_q  <= 1'b0;
      tme_q <= 1'b0;
      sel_q <= '0;
    end else if (wr_ctl) begin
      wt_q  <= wdata_i[6];
      tme_q <= wdata_i[5];
      sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pre_q <= '0;
    else if (!tme_q || tick)            pre_q <= '0;
    else if (wr_ctl && !wdata_i[5])     pre_q <= '0;
    else                                pre_q <= pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= 8'h00;
    else if (wr_cnt)  cnt_q <= wdata_i[7:0];
    else if (tick)    cnt_q <= cnt_q + 8'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rste_q <= 1'b0;
    else if (wr_rcr)  rste_q <= wdata_i[6];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (set_flag) begin
      ovf_q  <= 1'b1;
      seen_q <= 1'b0;
    end else if (clr_rq && seen_q) begin
      ovf_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (rd_rcr && ovf_q) begin
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pls_q <= '0;
    else if (fire)        pls_q <= PULSE_W'(PULSE_LEN);
    else if (pls_q != 0)  pls_q <= pls_q - PULSE_W'(1);
  end

  assign reset_o = pls_q != '0;

  always_comb begin
    rdata_o = 16'h0000;
    if (rd_en_i) begin
      case (addr_i)
        3'd0:    rdata_o = {8'h00, 1'b0, wt_q, tme_q, 5'(sel_q)};
        3'd2:    rdata_o = {8'h00, cnt_q};
        3'd4:    rdata_o = {8'h00, ovf_q, rste_q, 6'b0};
        default: rdata_o = 16'h0000;
      endcase
    end
  end

  a_r2_ctl_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0 && wdata_i[15:8] != KEY_CTL) |=> $stable({wt_q, tme_q, sel_q}));

  a_r9_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tme_q && !(wr_en_i && addr_i == 3'd2 && wdata_i[15:8] == KEY_DAT)) |=> $stable(cnt_q));

  a_r6_flag_needs_wdt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(wt_q && tme_q && cnt_q == 8'hFF));

  a_r7_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_o) |-> $past(rste_q && wt_q && ovf_q == 1'b0 || rste_q && wt_q));

  a_r7_flag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_en_i && addr_i == 3'd4 && wdata_i == CLR_WORD)) |=> ovf_q);

  a_r8_clear_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> $past(seen_q && wr_en_i && addr_i == 3'd4 && wdata_i == CLR_WORD));

endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        reset_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  keyed_wdt uut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
                 .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .reset_o(reset_o));

  always @(negedge clk) begin
    if (rd_en && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(posedge clk) #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk) #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] e, string tag);
    @(posedge clk) #1;
    rd_en = 1'b1; addr = a;
    sbq.push_back('{e, tag});
    @(posedge clk) #1;
    rd_en = 1'b0;
  endtask

  task automatic run_for(logic [7:0] ctl, int n);
    wr(3'd0, {8'hA5, ctl});
    repeat (n - 2) @(posedge clk);
    wr(3'd0, 16'hA500);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int highs;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    check(reset_o == 1'b0, "R1 reset_o low", reset_o, 0);
    rd(3'd0, 16'h0000, "R1 control reset");
    rd(3'd2, 16'h0000, "R1 count reset");
    rd(3'd4, 16'h0000, "R1 reset-ctl reset");

    wr(3'd0, 16'h5A65);
    rd(3'd0, 16'h0000, "R2 control wrong key");
    wr(3'd0, 16'hA547);
    rd(3'd0, 16'h0047, "R3 control readback");
    wr(3'd0, 16'hA500);
    wr(3'd2, 16'h5A10);
    rd(3'd2, 16'h0010, "R10 count load");
    wr(3'd2, 16'hA533);
    rd(3'd2, 16'h0010, "R2 count wrong key");
    wr(3'd4, 16'h1240);
    rd(3'd4, 16'h0000, "R2 reset-ctl wrong key");

    wr(3'd2, 16'h5AFE);
    run_for(8'h20, 2);
    rd(3'd2, 16'h0000, "R6 interval wrap count");
    rd(3'd4, 16'h0000, "R6 no flag in interval mode");
    repeat (10) @(posedge clk);
    rd(3'd2, 16'h0000, "R9 stopped counter holds");

    wr(3'd2, 16'h5A00); run_for(8'h21, 40);
    rd(3'd2, 16'h000A, "R4 divide by 4");
    wr(3'd2, 16'h5A00); run_for(8'h23, 128);
    rd(3'd2, 16'h0002, "R4 divide by 64");
    wr(3'd2, 16'h5A00); run_for(8'h27, 16383);
    rd(3'd2, 16'h0000, "R4 largest divide, one edge short");
    run_for(8'h27, 16384);
    rd(3'd2, 16'h0001, "R4 largest divide, exact");

    wr(3'd4, 16'h5A40);
    rd(3'd4, 16'h0040, "R10 reset enable readback");
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (reset_o) highs++;
    end
    check(highs == 16, "R7 pulse length", highs, 16);
    wr(3'd0, 16'hA500);
    wr(3'd4, 16'hA500);
    rd(3'd4, 16'h00C0, "R8 clear ignored before read");
    wr(3'd4, 16'hA500);
    rd(3'd4, 16'h0040, "R8 clear after read");
    wr(3'd2, 16'h5A77);
    rd(3'd2, 16'h0077, "R9 reload while stopped");

    wr(3'd4, 16'h5A00);
    wr(3'd2, 16'h5AFC);
    run_for(8'h60, 3);
    rd(3'd4, 16'h0000, "R5 no overflow after 3 ticks from FC");
    rd(3'd2, 16'h00FF, "R5 count after 3 ticks");
    run_for(8'h60, 2);
    rd(3'd4, 16'h0080, "R5 overflow on fourth tick");
    rd(3'd2, 16'h0001, "R5 count after wrap");
    check(reset_o == 1'b0, "R7 no pulse with reset disabled", reset_o, 0);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule